// File: doc/BRIEF.md
# Asynchronous static RAM access sequencer

This block lets synchronous logic use a 32K x 8 asynchronous static RAM. A requester offers one access at a time on a valid/ready handshake: a 15-bit word address, a write flag and a byte of write data. The sequencer turns each accepted access into a timed series of memory control levels: active-low chip select, write enable and output enable, a registered address, and a data bus split into an output value, an output-enable and an input. A read returns its byte with a one-cycle valid strobe.

Every timing interval is a parameter counted in clock cycles:

- the address/data setup before the write strobe,
- the write strobe width,
- the write recovery after the strobe,
- the read access wait.

Writes are strobed by write enable inside an enclosing chip-select window. The address only moves while chip select is inactive. Output enable stays inactive for the whole write, so the strobe only has to meet its own minimum width. Between a write and a read there is always one idle cycle in which nobody drives the data bus.

Top module: `sram_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, chip select, write enable and output enable are all high (inactive), the data bus output-enable is low, ready is high and the response valid strobe is low.
- R2: An accepted write holds chip select low for SETUP_CYC + PULSE_CYC + RECOV_CYC consecutive cycles, with these phases in order: SETUP_CYC cycles with write enable high, then PULSE_CYC cycles with write enable low, then RECOV_CYC cycles with write enable high. Write enable is never low unless chip select is low.
- R3: During a write, the data bus output-enable is high from the first setup cycle through the last recovery cycle, and the bus carries the accepted write data during that window. The data bus output-enable is never high outside a write.
- R4: Output enable stays high during every write cycle, including every cycle in which write enable is low.
- R5: An accepted read holds chip select and output enable low and write enable high for exactly ACCESS_CYC cycles. The byte on the data input in the last of those cycles is returned on the response data. The response valid strobe is high for exactly one cycle, the (ACCESS_CYC+1)-th cycle after the acceptance edge.
- R6: The memory address takes the requested address on the acceptance edge. It never changes from one cycle to the next while chip select stays low.
- R7: Output enable never goes low in a cycle directly after one in which the data bus output-enable was high. A read accepted on the first idle cycle after a write therefore sees one cycle of released bus.
- R8: Ready is low while an access is in progress and high once the sequencer is idle again. Request fields and valid presented while ready is low have no effect on the memory pins.
- R9: After any series of writes, a read of an address returns the byte of the most recent write to that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle; request accepted on a clock edge with valid high |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe: read byte available |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 15 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | 1 = drive mem_dq_out onto the data bus |
| mem_dq_in | input | 8 | Data received from the memory bus |

## Verification
The hardest case to reach is a read accepted on the very first idle cycle after a write's recovery phase. Only in that case is the bus released for exactly one cycle before output enable falls. The bench chains its request tasks with no spare cycle, so each task presents the next request on the same falling edge where it observes ready return. A sweep of write-then-read pairs on fresh addresses therefore lands on this gap every time. The same tasks hold a decoy request on the port during busy periods, to show that it never reaches the memory pins.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_RECOV,
    ST_RDWAIT
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } pin_ctl_t;

  localparam pin_ctl_t CTL_INACTIVE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  function automatic pin_ctl_t ctl_for(seq_state_t s);
    pin_ctl_t c;
    c = CTL_INACTIVE;
    case (s)
      ST_SETUP:  begin c.cs_n = 1'b0; c.drive = 1'b1; end
      ST_PULSE:  begin c.cs_n = 1'b0; c.we_n = 1'b0; c.drive = 1'b1; end
      ST_RECOV:  begin c.cs_n = 1'b0; c.drive = 1'b1; end
      ST_RDWAIT: begin c.cs_n = 1'b0; c.oe_n = 1'b0; end
      default:   c = CTL_INACTIVE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 1,
  parameter int RECOV_CYC  = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       start_wr,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       phase_last
);

  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B   = (RECOV_CYC > ACCESS_CYC) ? RECOV_CYC : ACCESS_CYC;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign phase_last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = start_wr ? ST_SETUP : ST_RDWAIT;
          cnt_d   = start_wr ? LD_SETUP : LD_ACCESS;
        end
      end
      ST_SETUP: begin
        if (phase_last) begin
          state_d = ST_PULSE;
          cnt_d   = LD_PULSE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PULSE: begin
        if (phase_last) begin
          state_d = ST_RECOV;
          cnt_d   = LD_RECOV;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOV, ST_RDWAIT: begin
        if (phase_last) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state_q,
  input  seq_state_t        state_d,
  input  logic              phase_last,
  input  logic              accept,
  input  logic              accept_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  pin_ctl_t ctl_q;
  logic     capture;

  assign capture   = (state_q == ST_RDWAIT) && phase_last;
  assign mem_cs_n  = ctl_q.cs_n;
  assign mem_we_n  = ctl_q.we_n;
  assign mem_oe_n  = ctl_q.oe_n;
  assign mem_dq_oe = ctl_q.drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= CTL_INACTIVE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
    end else begin
      ctl_q     <= ctl_for(state_d);
      req_ready <= (state_d == ST_IDLE);
      rsp_valid <= capture;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
      end
      if (accept_wr) begin
        mem_dq_out <= req_wdata;
      end
      if (capture) begin
        rsp_rdata <= mem_dq_in;
      end
    end
  end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 1,
  parameter int RECOV_CYC  = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  seq_state_t state_q, state_d;
  logic       phase_last;
  logic       accept;

  assign accept = req_valid && req_ready;

  sram_seq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .RECOV_CYC (RECOV_CYC),
    .ACCESS_CYC(ACCESS_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .start_wr  (req_write),
    .state_q   (state_q),
    .state_d   (state_d),
    .phase_last(phase_last)
  );

  sram_seq_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .state_d   (state_d),
    .phase_last(phase_last),
    .accept    (accept),
    .accept_wr (accept && req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  AST_RESET_INACTIVE: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid)); // R1

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n); // R2

  AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe); // R3

  AST_OE_OFF_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || mem_dq_oe) |-> mem_oe_n); // R4

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |=> (mem_cs_n || $stable(mem_addr))); // R6

  AST_BUS_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !req_ready); // R8

endmodule

bind sram_seq sram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_cs_n (mem_cs_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_seq_bench.sv
`timescale 1ns/1ps
module sram_seq_bench;

  localparam int S = 2;
  localparam int P = 3;
  localparam int R = 1;
  localparam int A = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int checks = 0;
  int errors = 0;

  logic [7:0] model   [0:255];
  logic [7:0] exp_mem [0:255];

  always #2.5 clk = ~clk;

  sram_seq #(
    .SETUP_CYC(S), .PULSE_CYC(P), .RECOV_CYC(R), .ACCESS_CYC(A)
  ) u_sram_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Memory model: drives only in a read, stores during the low/low overlap
  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? model[mem_addr[7:0]] : 8'hEE;

  // Protocol monitor
  int   v_addr = 0, v_oe_wr = 0, v_gap = 0, v_drive = 0;
  logic p_cs_n = 1'b1, p_dq_oe = 1'b0;
  logic [14:0] p_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_cs_n && !mem_we_n) model[mem_addr[7:0]] <= mem_dq_out;
      if (!p_cs_n && !mem_cs_n && mem_addr != p_addr) v_addr++;
      if ((!mem_we_n || mem_dq_oe) && !mem_oe_n) v_oe_wr++;
      if (!mem_oe_n && p_dq_oe) v_gap++;
      if (mem_dq_oe && mem_cs_n) v_drive++;
    end
    p_cs_n  = mem_cs_n;
    p_dq_oe = mem_dq_oe;
    p_addr  = mem_addr;
  end

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [14:0] addr_of(input int i);
    return {7'(i * 19 + 3), 8'(i)};
  endfunction

  function automatic logic [7:0] data_of(input int i);
    return 8'(i * 29 + 11);
  endfunction

  // Caller stands at a falling edge; returns at the falling edge where ready is back
  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input bit noise);
    int busy = 0, su = 0, pw = 0, rc = 0, drv = 0, bad_d = 0, moves = 0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    forever begin
      @(negedge clk);
      if (noise) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
      end else begin
        req_valid = 1'b0;
      end
      if (req_ready || busy > 40) break;
      busy++;
      if (!mem_we_n) pw++;
      else if (!mem_cs_n) begin
        if (pw == 0) su++; else rc++;
      end
      if (mem_dq_oe) begin
        drv++;
        if (mem_dq_out != d) bad_d++;
      end
      if (mem_addr != a) moves++;
    end
    req_valid = 1'b0;
    exp_mem[a[7:0]] = d;
    check(su == S && pw == P && rc == R, "R2",
          $sformatf("phases setup/pulse/recov actual %0d/%0d/%0d expected %0d/%0d/%0d", su, pw, rc, S, P, R));
    check(drv == S + P + R && bad_d == 0, "R3",
          $sformatf("driven cycles %0d wrong-data %0d expected %0d and 0", drv, bad_d, S + P + R));
    check(busy == S + P + R && moves == 0, "R8",
          $sformatf("busy cycles %0d addr moves %0d expected %0d and 0", busy, moves, S + P + R));
  endtask

  task automatic do_read(input logic [14:0] a, input logic [7:0] expd);
    int n = 0, acc = 0, at = -1;
    logic [7:0] got = 8'h00;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) acc++;
      if (rsp_valid) begin
        at = n; got = rsp_rdata;
        break;
      end
      if (n > 40) break;
    end
    check(acc == A && at == A + 1, "R5",
          $sformatf("access cycles %0d response at %0d expected %0d and %0d", acc, at, A, A + 1));
    check(got == expd, "R9",
          $sformatf("addr %h read %h expected %h", a, got, expd));
    check(req_ready == 1'b1, "R8",
          $sformatf("ready at response %0b expected 1", req_ready));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i]   = 8'h00;
      exp_mem[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1",
          $sformatf("cs/we/oe/drive %b%b%b%b expected 1110", mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe));
    check(req_ready && !rsp_valid, "R1",
          $sformatf("ready/rsp %b%b expected 10", req_ready, rsp_valid));
    rst = 1'b0;
    @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, "R1",
          "controls after reset release not inactive, expected all inactive");

    // Fill sweep, some writes with a decoy request held while busy (R8)
    for (int i = 0; i < 128; i++) begin
      do_write(addr_of(i), data_of(i), (i % 5) == 0);
      if ((i % 5) == 0) begin
        @(negedge clk);
        check(mem_cs_n, "R8", $sformatf("decoy started an access: cs_n %b expected 1", mem_cs_n));
      end
    end
    for (int i = 0; i < 128; i++) do_read(addr_of(i), data_of(i));

    // Back-to-back write then read on the first idle cycle (R7, R9)
    for (int i = 128; i < 192; i++) begin
      do_write(addr_of(i), ~data_of(i), 1'b0);
      do_read(addr_of(i), ~data_of(i));
    end

    // Overwrite: latest write wins (R9)
    do_write(addr_of(7), 8'hA5, 1'b0);
    do_write(addr_of(7), 8'h3C, 1'b0);
    do_read(addr_of(7), 8'h3C);
    do_read(addr_of(8), data_of(8));

    repeat (3) @(negedge clk);
    check(v_addr == 0, "R6", $sformatf("address moves under chip select %0d expected 0", v_addr));
    check(v_oe_wr == 0, "R4", $sformatf("output enable low during write %0d expected 0", v_oe_wr));
    check(v_gap == 0, "R7", $sformatf("output enable low right after drive %0d expected 0", v_gap));
    check(v_drive == 0, "R3", $sformatf("bus driven outside write %0d expected 0", v_drive));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule